// File: doc/BRIEF.md
# Packet Buffer Slot Allocator

This block manages the slot pool of a network controller's packet buffer. A host drives a small register interface: it writes a command code to ask for a free slot, to give a slot back, or to wipe the whole pool. A free bitmap tracks which slots are taken. A granted slot number appears in a result register, is also loaded into a packet-select register, and is announced by a one-cycle interrupt pulse.

A command runs on the cycle after its write strobe ends, not while the strobe is held. An allocation that finds no free slot does not fail for good. It stays pending, and it completes by itself as soon as a release frees a slot. A release is a multi-cycle operation. A BUSY flag covers it, and further release commands that arrive while BUSY is set are dropped. Release requests come either from the packet-select register or from a hook input driven by the receive queue, which carries the number of its head packet. The usual host sequence is: write the allocate command, wait for the done pulse, then read the result register.

Top module: `pkt_slot_mgr`

## Requirements
- R1: After hardware reset, all 32 slots are free, the FAILED flag (result register bit 7) is 1, the packet-select and result slot numbers are 0, BUSY is 0, and the error and pending bits are 0.
- R2: A command write is a host write to address 0, with the opcode in data bits [7:5]. The command takes effect on the first cycle in which that write is no longer being presented. While the strobe is held, BUSY and FAILED do not change.
- R3: Opcode 1 (allocate) takes the lowest-numbered free slot. It writes that number to result bits [4:0] and to the packet-select register, clears FAILED, and pulses `allocDone` high for exactly one cycle.
- R4: If no slot is free, allocate sets FAILED and the pending bit (status bit 0). The request then completes on its own once a release frees a slot, with the same effects as R3.
- R5: An allocate issued while one is pending is ignored, and it sets the sticky error bit (status bit 1).
- R6: Opcode 4 releases the slot given on `rxHeadNum`, and opcode 5 releases the slot held in the packet-select register. BUSY (address 0, bit 0) reads 1 for exactly 4 cycles, after which the slot is free.
- R7: A release command that arrives while BUSY is 1 is dropped. It leaves the pool and the running release untouched.
- R8: Releasing a slot that is already free leaves the pool unchanged and sets the sticky error bit.
- R9: Opcode 2 frees every slot, clears the packet-select register, sets FAILED, and clears the pending bit, the error bit and any running release.
- R10: Opcodes 0, 3, 6 and 7 change nothing. Command data bits [4:0] are ignored by every opcode.
- R11: Read map: address 0 gives {0, BUSY}; address 1 gives the packet-select register in bits [4:0]; address 2 gives {FAILED, 00, result slot}; address 3 gives {0, error, pending}. A write to address 1 loads bits [4:0] into the packet-select register, except on a cycle where an allocation grant overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe, held for one or more cycles |
| hostAddr | input | 2 | Register address for reads and writes |
| hostWrData | input | 8 | Write data: opcode in [7:5], slot number in [4:0] |
| hostRdData | output | 8 | Combinational read data for `hostAddr` |
| rxHeadNum | input | 5 | Slot number that opcode 4 releases (receive queue hook) |
| allocDone | output | 1 | One-cycle pulse when an allocation is granted |

## Verification
The hardest state to reach from the ports is a pending allocation that gets satisfied automatically. To reach it, every one of the 32 slots must be held, an allocate must fail, and a release must then run through its full 4-cycle BUSY window before the grant fires. The bench gets there with a directed fill loop of 32 allocations. It then issues a failing allocate and a second, rejected allocate, and releases one chosen slot through the receive hook. After that, seeded random command streams with random strobe lengths are compared against a bench model of the pool. A separate directed case releases a slot while another release is still busy, to show that the second request is dropped.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;
  localparam int SLOTS      = 32;
  localparam int ID_W       = $clog2(SLOTS);
  localparam int REL_CYCLES = 4;
  localparam int DATA_W     = 8;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_CLEAR   = 3'd2,
    OP_REL_RX  = 3'd4,
    OP_REL_SEL = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    RA_CMD    = 2'd0,
    RA_SEL    = 2'd1,
    RA_RESULT = 2'd2,
    RA_STAT   = 2'd3
  } raddr_e;

  typedef struct packed {
    logic            clearAll;
    logic            allocAccept;
    logic            allocTry;
    logic            seqErr;
    logic            relDone;
    logic [ID_W-1:0] relNum;
  } ctl_stb_t;
endpackage

// File: rtl/pkt_slot_ctrl.sv
module pkt_slot_ctrl
  import pkt_slot_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWr,
  input  logic [1:0]      hostAddr,
  input  logic [OP_W-1:0] opField,
  input  logic [ID_W-1:0] rxHeadNum,
  input  logic [ID_W-1:0] pktSel,
  input  logic            anyFree,
  output ctl_stb_t        stb,
  output logic            busy,
  output logic            allocPend
);
  localparam int CNT_W = (REL_CYCLES > 1) ? $clog2(REL_CYCLES) : 1;

  logic            cmdHit, cmdArmed, exec, relStart;
  op_e             cmdOp;
  logic [CNT_W-1:0] relCnt;
  logic [ID_W-1:0] relTgt, relSel;

  assign cmdHit = hostWr && (hostAddr == RA_CMD);
  assign exec   = cmdArmed && !cmdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdArmed <= 1'b0;
      cmdOp    <= OP_NOP;
    end else begin
      cmdArmed <= cmdHit;
      if (cmdHit) cmdOp <= op_e'(opField);
    end
  end

  always_comb begin
    stb      = '0;
    relStart = 1'b0;
    relSel   = rxHeadNum;
    if (exec) begin
      case (cmdOp)
        OP_ALLOC: begin
          if (allocPend) stb.seqErr = 1'b1;
          else           stb.allocAccept = 1'b1;
        end
        OP_CLEAR: stb.clearAll = 1'b1;
        OP_REL_RX, OP_REL_SEL: begin
          relStart = !busy;
          relSel   = (cmdOp == OP_REL_SEL) ? pktSel : rxHeadNum;
        end
        default: ;
      endcase
    end
    stb.allocTry = (allocPend || stb.allocAccept) && !stb.clearAll;
    stb.relDone  = busy && (relCnt == '0);
    stb.relNum   = relTgt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      relCnt    <= '0;
      relTgt    <= '0;
      allocPend <= 1'b0;
    end else if (stb.clearAll) begin
      busy      <= 1'b0;
      relCnt    <= '0;
      allocPend <= 1'b0;
    end else begin
      if (relStart) begin
        busy   <= 1'b1;
        relCnt <= CNT_W'(REL_CYCLES - 1);
        relTgt <= relSel;
      end else if (busy) begin
        if (relCnt == '0) busy <= 1'b0;
        else              relCnt <= relCnt - 1'b1;
      end
      if (stb.allocTry && anyFree) allocPend <= 1'b0;
      else if (stb.allocAccept)    allocPend <= 1'b1;
    end
  end

  // checker: length of each BUSY window
  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(stb.clearAll)) |-> (busyRun == (CNT_W+1)'(REL_CYCLES)));

  a_r7_drop_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && exec && !stb.relDone && !stb.clearAll &&
     (cmdOp == OP_REL_RX || cmdOp == OP_REL_SEL))
    |=> (busy && $stable(relTgt)));

  a_r2_no_exec_while_held: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit |=> $stable(busy) || !busy || $past(busy));
endmodule

// File: rtl/pkt_slot_dp.sv
module pkt_slot_dp
  import pkt_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_stb_t          stb,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [ID_W-1:0]   selField,
  input  logic              busy,
  input  logic              allocPend,
  output logic [DATA_W-1:0] hostRdData,
  output logic [ID_W-1:0]   pktSel,
  output logic              anyFree,
  output logic              allocDone
);
  logic [SLOTS-1:0] freeMap, freeNext;
  logic [ID_W-1:0]  grantNum, resNum;
  logic             failed, errFlag, grant, selWr;

  always_comb begin
    anyFree  = |freeMap;
    grantNum = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (freeMap[i]) grantNum = ID_W'(i);
  end

  assign grant = stb.allocTry && anyFree;
  assign selWr = hostWr && (hostAddr == RA_SEL);

  always_comb begin
    freeNext = freeMap;
    if (grant) freeNext[grantNum] = 1'b0;
    if (stb.relDone && !freeMap[stb.relNum]) freeNext[stb.relNum] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeMap   <= '1;
      pktSel    <= '0;
      resNum    <= '0;
      failed    <= 1'b1;
      errFlag   <= 1'b0;
      allocDone <= 1'b0;
    end else begin
      allocDone <= grant;
      if (stb.clearAll) begin
        freeMap <= '1;
        pktSel  <= '0;
        failed  <= 1'b1;
        errFlag <= 1'b0;
      end else begin
        freeMap <= freeNext;
        if (grant) begin
          resNum <= grantNum;
          pktSel <= grantNum;
          failed <= 1'b0;
        end else begin
          if (stb.allocAccept) failed <= 1'b1;
          if (selWr)           pktSel <= selField;
        end
        if (stb.seqErr || (stb.relDone && freeMap[stb.relNum])) errFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    case (raddr_e'(hostAddr))
      RA_CMD:    hostRdData[0] = busy;
      RA_SEL:    hostRdData[ID_W-1:0] = pktSel;
      RA_RESULT: begin
        hostRdData[ID_W-1:0]  = resNum;
        hostRdData[DATA_W-1] = failed;
      end
      default: begin
        hostRdData[0] = allocPend;
        hostRdData[1] = errFlag;
      end
    endcase
  end

  a_r4_pend_implies_failed: assert property (@(posedge clk) disable iff (!rstN)
    allocPend |-> failed);

  a_r3_grant_taken: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> (!freeMap[resNum] && !failed && pktSel == resNum));

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |=> !allocDone);

  a_r8_free_only_by_release: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(freeMap) > $past($countones(freeMap))) |-> $past(stb.relDone || stb.clearAll));
endmodule

// File: rtl/pkt_slot_mgr.sv
module pkt_slot_mgr
  import pkt_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [ID_W-1:0]   rxHeadNum,
  output logic              allocDone
);
  ctl_stb_t        stb;
  logic            busy, allocPend, anyFree;
  logic [ID_W-1:0] pktSel;

  pkt_slot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .opField   (hostWrData[DATA_W-1 -: OP_W]),
    .rxHeadNum (rxHeadNum),
    .pktSel    (pktSel),
    .anyFree   (anyFree),
    .stb       (stb),
    .busy      (busy),
    .allocPend (allocPend)
  );

  pkt_slot_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .selField   (hostWrData[ID_W-1:0]),
    .busy       (busy),
    .allocPend  (allocPend),
    .hostRdData (hostRdData),
    .pktSel     (pktSel),
    .anyFree    (anyFree),
    .allocDone  (allocDone)
  );
endmodule

// File: tb/test_pkt_slot_mgr.sv
`timescale 1ns/1ps
module test_pkt_slot_mgr;
  logic       clk = 1'b0, rstN = 1'b0, hostWr = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'd0, hostRdData;
  logic [4:0] rxHeadNum = 5'd0;
  logic       allocDone;
  int total = 0, bad = 0, irqCnt = 0;
  bit done = 0;

  logic [31:0] mFree;
  int  mSel, mRes;
  bit  mFailed, mPend, mErr;

  pkt_slot_mgr i_pkt_slot_mgr (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .rxHeadNum(rxHeadNum), .allocDone(allocDone)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rstN && allocDone === 1'b1) irqCnt++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    hostAddr = 2'(a);
    #1 v = int'(hostRdData);
  endtask

  function automatic int lowestFree();
    for (int i = 0; i < 32; i++) if (mFree[i]) return i;
    return -1;
  endfunction

  task automatic modelCmd(input int op, output int eIrq);
    int t, lf;
    eIrq = 0;
    t = (op == 4) ? int'(rxHeadNum) : mSel;
    case (op)
      1: begin
        lf = lowestFree();
        if (mPend) mErr = 1;
        else if (lf >= 0) begin
          mFree[lf] = 1'b0; mRes = lf; mSel = lf; mFailed = 0; eIrq = 1;
        end else begin
          mPend = 1; mFailed = 1;
        end
      end
      2: begin mFree = '1; mSel = 0; mFailed = 1; mPend = 0; mErr = 0; end
      4, 5: begin
        if (mFree[t]) mErr = 1;
        else begin
          mFree[t] = 1'b1;
          if (mPend) begin
            lf = lowestFree();
            mFree[lf] = 1'b0; mRes = lf; mSel = lf; mFailed = 0; mPend = 0; eIrq = 1;
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic issue(input int op, input int arg, input int hold);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 2'd0; hostWrData = {3'(op), 5'(arg)};
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    hostWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic setSel(input int v);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 2'd1; hostWrData = 8'(v);
    @(negedge clk);
    hostWr = 1'b0;
    mSel = v;
  endtask

  task automatic settle(input string req, input int eIrq, input int irq0);
    int v;
    repeat (7) @(negedge clk);
    rd(0, v); chk({req, " busy idle"}, v, 0);
    rd(1, v); chk({req, " select reg"}, v, mSel);
    rd(2, v); chk({req, " result reg"}, v, int'(mFailed) * 128 + mRes);
    rd(3, v); chk({req, " status reg"}, v, int'(mErr) * 2 + int'(mPend));
    chk({req, " done pulses"}, irqCnt - irq0, eIrq);
  endtask

  task automatic doOp(input string req, input int op, input int arg, input int hold);
    int e, i0;
    i0 = irqCnt;
    modelCmd(op, e);
    issue(op, arg, hold);
    settle(req, e, i0);
  endtask

  initial begin
    int v, e, i0, r;
    void'($urandom(32'd7321));
    mFree = '1; mSel = 0; mRes = 0; mFailed = 1; mPend = 0; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 done low after reset", int'(allocDone), 0);
    settle("R1 reset state", 0, irqCnt);

    for (int k = 0; k < 4; k++) doOp("R3 allocate lowest", 1, 0, 1);
    rd(2, v); chk("R3 fourth grant slot", v & 31, 3);

    // R2: strobe held three cycles, BUSY must stay low until it ends
    i0 = irqCnt; rxHeadNum = 5'd3;
    modelCmd(4, e);
    @(negedge clk); hostWr = 1'b1; hostAddr = 2'd0; hostWrData = {3'd4, 5'd0};
    @(negedge clk); #1 chk("R2 busy while held 1", int'(hostRdData[0]), 0);
    @(negedge clk); #1 chk("R2 busy while held 2", int'(hostRdData[0]), 0);
    @(negedge clk); hostWr = 1'b0;
    @(negedge clk); #1 chk("R2 busy after strobe end", int'(hostRdData[0]), 1);
    settle("R2 trailing edge release", e, i0);

    // R6: BUSY window length on a select-register release
    setSel(1);
    i0 = irqCnt;
    modelCmd(5, e);
    issue(5, 0, 1);
    rd(0, v); chk("R6 busy cycle 1", v, 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk); rd(0, v); chk("R6 busy window", v, 1);
    end
    @(negedge clk); rd(0, v); chk("R6 busy ends after 4", v, 0);
    settle("R6 release by select", e, i0);
    doOp("R6 freed slot reused", 1, 0, 1);
    rd(2, v); chk("R6 reuse slot 1", v & 31, 1);

    // R7: a second release during BUSY is dropped
    setSel(0);
    i0 = irqCnt;
    modelCmd(5, e);
    issue(5, 0, 1);
    rxHeadNum = 5'd2;
    issue(4, 0, 1);
    settle("R7 dropped release", e, i0);
    doOp("R7 alloc after drop", 1, 0, 1);
    doOp("R7 alloc skips held slot", 1, 0, 1);
    rd(2, v); chk("R7 slot 2 still held", v & 31, 3);
    doOp("R6 release by head hook", 4, 0, 1);

    rxHeadNum = 5'd20;
    doOp("R8 double free", 4, 0, 1);
    rd(3, v); chk("R8 error bit", (v >> 1) & 1, 1);

    doOp("R9 clear pool", 2, 0, 1);
    doOp("R9 alloc after clear", 1, 0, 1);
    rd(2, v); chk("R9 first slot again", v, 0);

    doOp("R9 clear before fill", 2, 0, 1);
    for (int k = 0; k < 32; k++) doOp("R4 fill pool", 1, 0, 1);
    doOp("R4 exhausted allocate", 1, 0, 1);
    rd(3, v); chk("R4 pending bit", v & 1, 1);
    doOp("R5 second allocate rejected", 1, 0, 1);
    rxHeadNum = 5'd17;
    doOp("R4 pending granted on release", 4, 0, 1);
    rd(2, v); chk("R4 granted slot", v, 17);

    doOp("R10 opcode 0", 0, 21, 1);
    doOp("R10 opcode 3", 3, 9, 2);
    doOp("R10 opcode 6", 6, 31, 1);
    doOp("R10 opcode 7", 7, 4, 3);
    doOp("R10 clear with args", 2, 31, 1);
    doOp("R10 allocate with args", 1, 31, 1);

    for (int n = 0; n < 300; n++) begin
      r = int'($urandom % 20);
      if (r < 8) doOp("R11 random allocate", 1, int'($urandom % 32), int'($urandom % 3) + 1);
      else if (r < 12) begin
        setSel(int'($urandom % 32));
        doOp("R11 random select release", 5, int'($urandom % 32), int'($urandom % 3) + 1);
      end else if (r < 15) begin
        rxHeadNum = 5'($urandom % 32);
        doOp("R11 random head release", 4, 0, int'($urandom % 3) + 1);
      end else if (r < 18) doOp("R11 random no-op", (r == 15) ? 0 : r - 9, int'($urandom % 32), 1);
      else if (r == 18) begin
        setSel(int'($urandom % 32));
        i0 = irqCnt;
        settle("R11 select write", 0, i0);
      end else doOp("R11 random clear", 2, 0, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule